// File: doc/BRIEF.md
# Timer Tick Level Request Latch

This block turns the pulse train of a free-running interval timer into an interrupt request that an interrupt controller can use when it only recognises level-sensitive requests. Each rising transition of the timer output sets a sticky latch. The latch drives the request output high, and the request stays high until software clears it. The request never drops by itself.

Software clears the request through bit 7 of an 8-bit system control register at I/O address 0x61. The interrupt handler writes that bit as 1 and then writes it back to 0. While the bit is 1, the latch is held clear and timer edges are not recorded. The other seven bits of the register are only stored and read back. The timer input comes from another clock domain, so it is synchronised before its edges are detected.

Top module: `tick_irq_latch`

## Requirements
- R1: After reset, irq_o is 0 and the control register reads back as 0x00.
- R2: A 0-to-1 transition on tmr_i drives irq_o high exactly three rising clock edges after tmr_i is first sampled high (two synchroniser stages, then the latch).
- R3: Once high, irq_o stays high when tmr_i falls and through further timer edges, until a clear occurs.
- R4: A write to address 0x61 with data bit 7 = 1 drives irq_o low on the second rising edge after the write edge.
- R5: While the stored bit 7 is 1, timer rising edges do not set the request, and irq_o stays 0.
- R6: After bit 7 is written back to 0, the next timer rising edge sets the request again. A timer edge that arrived while bit 7 was 1 is not recorded later.
- R7: A read of address 0x61 with rd_i = 1 returns all 8 stored bits as last written. Bits 0 to 6 have no effect on irq_o.
- R8: A write to any address other than 0x61 changes neither the register nor irq_o. rdata_o is 0x00 whenever rd_i is 0 or the address is not 0x61.
- R9: A timer output that stays high sets the request only once. After a clear, the request stays 0 until tmr_i goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tmr_i | input | 1 | Interval timer output, asynchronous to clk_i |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe, active for one cycle per write |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: the register at 0x61, otherwise zero |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 16-bit address, the control register at 0x61, the clear on bit 7 and a two-stage synchroniser. With two stages, the three-edge set latency and the two-edge clear latency are fixed, so both are checked on the exact cycle. The neighbouring address 0x60 is used to show that a decode off by one bit has no effect on the request or the stored value.

// File: rtl/tick_latch_pkg.sv
package tick_latch_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] ctrl_t;
endpackage

// File: rtl/tick_sync.sv
module tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tick_edge_det.sv
module tick_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tick_ctrl_reg.sv
module tick_ctrl_reg
  import tick_latch_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 16'h0061
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  ctrl_t             wdata_i,
  output ctrl_t             rdata_o,
  output ctrl_t             ctrl_o
);
  logic  hit;
  ctrl_t ctrl_q;

  assign hit = (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          ctrl_q <= '0;
    else if (wr_i && hit) ctrl_q <= wdata_i;

  assign rdata_o = (rd_i && hit) ? ctrl_q : '0;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/tick_req_latch.sv
module tick_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  // clear dominates a simultaneous set
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;

  assign q_o = q;
endmodule

// File: rtl/tick_irq_latch.sv
module tick_irq_latch
  import tick_latch_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h0061,
  parameter int unsigned       CLR_BIT     = 7,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  logic  tmr_sync;
  logic  set_pulse;
  ctrl_t ctrl_q;

  tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tmr_i), .q_o(tmr_sync)
  );

  tick_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(tmr_sync), .rise_o(set_pulse)
  );

  tick_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ctrl_o(ctrl_q)
  );

  tick_req_latch u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_pulse),
    .clr_i(ctrl_q[CLR_BIT]), .q_o(irq_o)
  );
endmodule

// File: rtl/tick_irq_latch_chk.sv
module tick_irq_latch_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0061,
  parameter int unsigned       CLR_BIT   = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              set_pulse,
  input logic [7:0]        ctrl_q,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic              irq_o
);
  assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse && !ctrl_q[CLR_BIT]) |=> irq_o);

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl_q[CLR_BIT]) |=> irq_o);

  assert_hold_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CLR_BIT] |=> !irq_o);

  assert_only_edge_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(set_pulse));

  assert_rdata_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == CTRL_ADDR) |-> (rdata_o == 8'h00));

  assert_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == CTRL_ADDR) |-> (rdata_o == ctrl_q));
endmodule

bind tick_irq_latch tick_irq_latch_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CLR_BIT(CLR_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .set_pulse(set_pulse), .ctrl_q(ctrl_q),
  .addr_i(addr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_o(irq_o)
);

// File: tb/tick_irq_latch_tb.sv
`timescale 1ns/100ps
module tick_irq_latch_tb;
  localparam logic [15:0] CTRL = 16'h0061;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  tick_irq_latch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_i(tmr), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = '0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0; addr = '0;
  endtask

  task automatic pulse_clear();
    bus_wr(CTRL, 8'h80);
    bus_wr(CTRL, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    bus_rd(CTRL, d);
    chk("R1 reg", d, 8'h00);
  endtask

  task automatic t_set_latency();
    tmr = 1'b1;
    cyc(2);
    chk("R2 before 3rd edge", {7'd0, irq}, 8'h00);
    cyc(1);
    chk("R2 at 3rd edge", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_sticky();
    tmr = 1'b0; cyc(5);
    chk("R3 after fall", {7'd0, irq}, 8'h01);
    tmr = 1'b1; cyc(5); tmr = 1'b0; cyc(5);
    chk("R3 after second edge", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_clear_and_hold();
    bus_wr(CTRL, 8'h80);
    chk("R4 one edge after write", {7'd0, irq}, 8'h01);
    cyc(1);
    chk("R4 two edges after write", {7'd0, irq}, 8'h00);
    tmr = 1'b1; cyc(6);
    chk("R5 edge during hold", {7'd0, irq}, 8'h00);
    bus_wr(CTRL, 8'h00); cyc(5);
    chk("R6 no late capture", {7'd0, irq}, 8'h00);
    tmr = 1'b0; cyc(4); tmr = 1'b1; cyc(4);
    chk("R6 capture resumes", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_steady_high();
    pulse_clear(); cyc(6);
    chk("R9 steady high no re-set", {7'd0, irq}, 8'h00);
    tmr = 1'b0; cyc(4); tmr = 1'b1; cyc(4);
    chk("R9 new edge sets", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    bus_wr(CTRL, 8'h5A); cyc(3);
    bus_rd(CTRL, d);
    chk("R7 readback 5A", d, 8'h5A);
    chk("R7 low bits keep irq", {7'd0, irq}, 8'h01);
    bus_wr(CTRL, 8'hA5); cyc(1);
    bus_rd(CTRL, d);
    chk("R7 readback A5", d, 8'hA5);
    cyc(2);
    chk("R7 bit7 clears", {7'd0, irq}, 8'h00);
    bus_wr(CTRL, 8'h00);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    tmr = 1'b0; cyc(4); tmr = 1'b1; cyc(4);
    bus_wr(16'h0060, 8'h80); cyc(3);
    chk("R8 foreign write irq", {7'd0, irq}, 8'h01);
    bus_wr(16'h0161, 8'hFF); cyc(3);
    chk("R8 alias write irq", {7'd0, irq}, 8'h01);
    bus_rd(CTRL, d);
    chk("R8 reg unchanged", d, 8'h00);
    bus_wr(CTRL, 8'h3C);
    bus_rd(16'h0060, d);
    chk("R8 foreign read zero", d, 8'h00);
    addr = CTRL; #1;
    chk("R8 no strobe zero", rdata, 8'h00);
    addr = '0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_set_latency();
    t_sticky();
    t_clear_and_hold();
    t_steady_high();
    t_readback();
    t_other_addr();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule